// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each cycle it receives the accumulator value, a second operand (memory byte or immediate), the index register value, an operation code, and the current status flags. From these it produces a result byte and the next values of the negative, overflow, zero and carry flags. Any flag that the selected operation does not define is copied straight from its input, so the surrounding sequencer can always write all four flags back.

Besides the ordinary arithmetic, logic, compare, bit-test, shift and rotate set, the unit also implements four fused operations. Each one masks the accumulator with the operand first and then shifts, rotates, copies a bit into carry, or subtracts. Their flag rules are irregular, and they are kept that way on purpose. Decimal correction for add and subtract is controlled by a parameter and is on by default.

Top module: `alu8_core`

## Requirements
- R1: With op_i=0, y_o equals a_i+b_i+c_i modulo 256. c_o is the carry out of bit 7, v_o is set when a_i and b_i have the same sign and y_o has the other sign, n_o is y_o bit 7, and z_o is set when y_o is zero.
- R2: With op_i=1, y_o equals a_i-b_i-(1-c_i) modulo 256. c_o=1 means no borrow occurred, v_o uses the R1 rule applied to the inverted b_i, and n_o and z_o follow y_o.
- R3: When d_i=1, ops 0 and 1 treat both operands as two packed decimal digits and apply per-digit correction. y_o is the decimal result, c_o is the decimal carry (or no-borrow), n_o and z_o come from the corrected result, and v_o comes from the binary sum.
- R4: op_i=2 compares a_i with b_i. y_o stays equal to a_i, c_o=1 when a_i>=b_i (unsigned), z_o=1 on equality, n_o is bit 7 of a_i-b_i, and v_o passes through. c_i and d_i have no effect.
- R5: Ops 3 (AND), 4 (OR), 5 (XOR), 15 (a_i+1), 16 (a_i-1) and 17 (load b_i) set y_o to their result and update only n_o and z_o. v_o and c_o pass through.
- R6: op_i=6 is a bit test. y_o stays equal to a_i, z_o=1 when a_i AND b_i is zero, n_o takes b_i bit 7, v_o takes b_i bit 6, and c_o passes through.
- R7: op_i=7 shifts a_i left with bit 0 cleared and the old bit 7 moved into c_o. op_i=8 shifts right with bit 7 cleared and the old bit 0 moved into c_o.
- R8: op_i=9 rotates a_i left with c_i entering bit 0. op_i=10 rotates right with c_i entering bit 7. In both, the bit shifted out goes to c_o.
- R9: op_i=11 sets y_o to a_i AND b_i, updates n_o and z_o, and sets c_o to y_o bit 7.
- R10: op_i=12 sets y_o to (a_i AND b_i) shifted right logically by one. c_o is bit 0 of the masked value.
- R11: op_i=13 forms m = a_i AND b_i and sets y_o = {c_i, m[7:1]}. c_o is m bit 6, v_o is m bit 7 XOR m bit 6, and n_o and z_o follow y_o. d_i is ignored.
- R12: op_i=14 sets y_o = (a_i AND x_i) - b_i modulo 256, with flags set as for a compare of (a_i AND x_i) against b_i. v_o passes through, and c_i and d_i have no effect.
- R13: op_i=18 and every code from 19 to 31 return y_o=a_i and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Accumulator or register operand |
| b_i | input | 8 | Memory or immediate operand |
| x_i | input | 8 | Index register, used by the masked subtract |
| op_i | input | 5 | Operation code |
| c_i | input | 1 | Carry flag in |
| d_i | input | 1 | Decimal-mode flag in |
| n_i | input | 1 | Negative flag in |
| v_i | input | 1 | Overflow flag in |
| z_i | input | 1 | Zero flag in |
| y_o | output | 8 | Result byte |
| n_o | output | 1 | Negative flag out |
| v_o | output | 1 | Overflow flag out |
| z_o | output | 1 | Zero flag out |
| c_o | output | 1 | Carry flag out |

## Verification
Add and subtract are driven with operands that overflow into the sign bit, wrap through zero, and run with each carry-in value. These cases separate a signed-overflow error from a carry error and show whether borrow has the wrong polarity. Decimal vectors are chosen so that each digit needs correction on its own, which exposes a missing per-nibble carry. The fused masked operations use masks that clear bit 6 or bit 7 independently, so swapped carry or overflow sources show up, and the compare-style paths are run with carry-in and decimal mode set to show that both are ignored. Flag inputs are set to the opposite of the expected outputs on every pass-through operation, so a flag that is overwritten when it should not be cannot go unnoticed.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_ADDC     = 5'd0,
      OP_SUBC     = 5'd1,
      OP_CMP      = 5'd2,
      OP_AND      = 5'd3,
      OP_OR       = 5'd4,
      OP_XOR      = 5'd5,
      OP_BTST     = 5'd6,
      OP_SHL      = 5'd7,
      OP_SHR      = 5'd8,
      OP_ROL      = 5'd9,
      OP_ROR      = 5'd10,
      OP_AND_CPY  = 5'd11,
      OP_AND_SHR  = 5'd12,
      OP_AND_ROR  = 5'd13,
      OP_MASK_SUB = 5'd14,
      OP_INC      = 5'd15,
      OP_DEC      = 5'd16,
      OP_LOAD     = 5'd17,
      OP_HOLD     = 5'd18
   } alu_op_e;

   typedef enum logic [2:0] {
      SH_LEFT  = 3'd0,
      SH_RIGHT = 3'd1,
      SH_ROL   = 3'd2,
      SH_ROR   = 3'd3,
      SH_INC   = 3'd4,
      SH_DEC   = 3'd5
   } shift_kind_e;

   typedef enum logic [1:0] {
      LG_AND   = 2'd0,
      LG_OR    = 2'd1,
      LG_XOR   = 2'd2,
      LG_PASSB = 2'd3
   } logic_kind_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         sub_i,
   input  logic         dec_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o,
   output logic         zero_o
);
   localparam int NIB = W / 4;

   if (W < 4) begin : g_chk_w
      $error("alu8_addsub: W must be at least 4");
   end
   if (DEC_EN && (W % 4 != 0)) begin : g_chk_dec
      $error("alu8_addsub: decimal mode needs W to be a multiple of 4");
   end

   logic [W-1:0] beff;
   logic [W-1:0] bsum;
   logic [W:0]   cy;
   logic [W-1:0] dsum;
   logic         dcout;
   logic         use_dec;

   assign beff  = sub_i ? ~b_i : b_i;
   assign cy[0] = cin_i;

   for (genvar i = 0; i < W; i++) begin : g_ripple
      assign bsum[i]  = a_i[i] ^ beff[i] ^ cy[i];
      assign cy[i+1]  = (a_i[i] & beff[i]) | (a_i[i] & cy[i]) | (beff[i] & cy[i]);
   end

   if (DEC_EN) begin : g_bcd
      logic [NIB:0] dcy;
      assign dcy[0] = cin_i;
      for (genvar k = 0; k < NIB; k++) begin : g_digit
         logic [4:0] t5;
         logic [3:0] dig;
         logic       fix;
         always_comb begin
            if (sub_i) begin
               t5  = {1'b0, a_i[4*k +: 4]} - {1'b0, b_i[4*k +: 4]} - {4'd0, ~dcy[k]};
               fix = t5[4];
               dig = fix ? (t5[3:0] - 4'd6) : t5[3:0];
            end else begin
               t5  = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]} + {4'd0, dcy[k]};
               fix = (t5 > 5'd9);
               dig = fix ? (t5[3:0] + 4'd6) : t5[3:0];
            end
         end
         assign dsum[4*k +: 4] = dig;
         assign dcy[k+1]       = sub_i ? ~fix : fix;
      end
      assign dcout = dcy[NIB];
   end else begin : g_nobcd
      assign dsum  = bsum;
      assign dcout = cy[W];
   end

   assign use_dec = dec_i && DEC_EN;
   assign sum_o   = use_dec ? dsum  : bsum;
   assign cout_o  = use_dec ? dcout : cy[W];
   assign ovf_o   = cy[W] ^ cy[W-1];
   assign zero_o  = (sum_o == '0);

   // binary ripple agrees with a behavioural sum; overflow follows the sign rule
   always_comb begin
      if (!use_dec) begin
         assert_binary_sum_R1: assert ({cout_o, sum_o} ==
            ({1'b0, a_i} + {1'b0, beff} + {{W{1'b0}}, cin_i}))
            else $error("ripple sum mismatch");
      end
      assert_sign_overflow_R2: assert (ovf_o ==
         ((a_i[W-1] == beff[W-1]) && (bsum[W-1] != a_i[W-1])))
         else $error("overflow rule mismatch");
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic_kind_e  kind_i,
   output logic [W-1:0] y_o,
   output logic         zero_o
);
   always_comb begin
      unique case (kind_i)
         LG_OR:    y_o = a_i | b_i;
         LG_XOR:   y_o = a_i ^ b_i;
         LG_PASSB: y_o = b_i;
         default:  y_o = a_i & b_i;
      endcase
   end

   assign zero_o = (y_o == '0);

   // a mask can only keep bits present in both operands (R5)
   always_comb begin
      if (kind_i == LG_AND) begin
         assert_and_subset_R5: assert (((y_o & ~a_i) == '0) && ((y_o & ~b_i) == '0))
            else $error("and result has stray bits");
      end
   end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] s_i,
   input  logic         c_i,
   input  shift_kind_e  kind_i,
   output logic [W-1:0] y_o,
   output logic         c_o,
   output logic         zero_o
);
   localparam int MSB = W - 1;

   always_comb begin
      y_o = s_i;
      c_o = c_i;
      unique case (kind_i)
         SH_LEFT:  begin y_o = {s_i[MSB-1:0], 1'b0}; c_o = s_i[MSB]; end
         SH_RIGHT: begin y_o = {1'b0, s_i[MSB:1]};   c_o = s_i[0];   end
         SH_ROL:   begin y_o = {s_i[MSB-1:0], c_i};  c_o = s_i[MSB]; end
         SH_ROR:   begin y_o = {c_i, s_i[MSB:1]};    c_o = s_i[0];   end
         SH_INC:   y_o = s_i + {{(W-1){1'b0}}, 1'b1};
         SH_DEC:   y_o = s_i - {{(W-1){1'b0}}, 1'b1};
         default:  ;
      endcase
   end

   assign zero_o = (y_o == '0);

   // rotates conserve ones through carry; shifts conserve the operand's ones
   always_comb begin
      if (kind_i == SH_ROL || kind_i == SH_ROR) begin
         assert_rotate_keeps_bits_R8: assert ($countones({c_o, y_o}) == $countones({c_i, s_i}))
            else $error("rotate lost a bit");
      end
      if (kind_i == SH_LEFT || kind_i == SH_RIGHT) begin
         assert_shift_keeps_bits_R7: assert ($countones({c_o, y_o}) == $countones(s_i))
            else $error("shift lost a bit");
      end
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] x_i,
   input  logic [4:0]   op_i,
   input  logic         c_i,
   input  logic         d_i,
   input  logic         n_i,
   input  logic         v_i,
   input  logic         z_i,
   output logic [W-1:0] y_o,
   output logic         n_o,
   output logic         v_o,
   output logic         z_o,
   output logic         c_o
);
   localparam int MSB = W - 1;

   if (W < 4) begin : g_chk_w
      $error("alu8_core: W must be at least 4");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic [W-1:0] masked;
   assign masked = a_i & b_i;

   // add / subtract with carry, optional decimal
   logic [W-1:0] ar_y;
   logic         ar_c, ar_v, ar_z, ar_sub;
   assign ar_sub = (op == OP_SUBC);

   alu8_addsub #(.W(W), .DEC_EN(BCD_EN)) u_arith (
      .a_i(a_i), .b_i(b_i), .cin_i(c_i), .sub_i(ar_sub), .dec_i(d_i),
      .sum_o(ar_y), .cout_o(ar_c), .ovf_o(ar_v), .zero_o(ar_z)
   );

   // binary difference for compare and masked subtract
   logic [W-1:0] dif_a, dif_y;
   logic         dif_c, dif_z, dif_v_unused;
   assign dif_a = (op == OP_MASK_SUB) ? (a_i & x_i) : a_i;

   alu8_addsub #(.W(W), .DEC_EN(1'b0)) u_diff (
      .a_i(dif_a), .b_i(b_i), .cin_i(1'b1), .sub_i(1'b1), .dec_i(1'b0),
      .sum_o(dif_y), .cout_o(dif_c), .ovf_o(dif_v_unused), .zero_o(dif_z)
   );

   // bitwise unit
   logic_kind_e  lg_kind;
   logic [W-1:0] lg_y;
   logic         lg_z;
   always_comb begin
      unique case (op)
         OP_OR:   lg_kind = LG_OR;
         OP_XOR:  lg_kind = LG_XOR;
         OP_LOAD: lg_kind = LG_PASSB;
         default: lg_kind = LG_AND;
      endcase
   end

   alu8_logic #(.W(W)) u_logic (
      .a_i(a_i), .b_i(b_i), .kind_i(lg_kind), .y_o(lg_y), .zero_o(lg_z)
   );

   // shift / rotate / step unit
   shift_kind_e  sh_kind;
   logic [W-1:0] sh_src, sh_y;
   logic         sh_c, sh_z;
   assign sh_src = (op == OP_AND_SHR || op == OP_AND_ROR) ? masked : a_i;
   always_comb begin
      unique case (op)
         OP_SHR, OP_AND_SHR: sh_kind = SH_RIGHT;
         OP_ROL:             sh_kind = SH_ROL;
         OP_ROR, OP_AND_ROR: sh_kind = SH_ROR;
         OP_INC:             sh_kind = SH_INC;
         OP_DEC:             sh_kind = SH_DEC;
         default:            sh_kind = SH_LEFT;
      endcase
   end

   alu8_shift #(.W(W)) u_shift (
      .s_i(sh_src), .c_i(c_i), .kind_i(sh_kind),
      .y_o(sh_y), .c_o(sh_c), .zero_o(sh_z)
   );

   // result and flag selection; undefined flags pass through
   always_comb begin
      y_o = a_i;
      n_o = n_i;
      v_o = v_i;
      z_o = z_i;
      c_o = c_i;
      case (op)
         OP_ADDC, OP_SUBC: begin
            y_o = ar_y; n_o = ar_y[MSB]; v_o = ar_v; z_o = ar_z; c_o = ar_c;
         end
         OP_CMP: begin
            n_o = dif_y[MSB]; z_o = dif_z; c_o = dif_c;
         end
         OP_MASK_SUB: begin
            y_o = dif_y; n_o = dif_y[MSB]; z_o = dif_z; c_o = dif_c;
         end
         OP_AND, OP_OR, OP_XOR, OP_LOAD: begin
            y_o = lg_y; n_o = lg_y[MSB]; z_o = lg_z;
         end
         OP_BTST: begin
            z_o = lg_z; n_o = b_i[MSB]; v_o = b_i[MSB-1];
         end
         OP_AND_CPY: begin
            y_o = lg_y; n_o = lg_y[MSB]; z_o = lg_z; c_o = lg_y[MSB];
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_INC, OP_DEC, OP_AND_SHR: begin
            y_o = sh_y; n_o = sh_y[MSB]; z_o = sh_z; c_o = sh_c;
         end
         OP_AND_ROR: begin
            y_o = sh_y; n_o = sh_y[MSB]; z_o = sh_z;
            c_o = masked[MSB-1];
            v_o = masked[MSB] ^ masked[MSB-1];
         end
         default: ;
      endcase
   end

   // cross-unit consistency checks
   always_comb begin
      if (op == OP_CMP) begin
         assert_cmp_keeps_a_R4: assert (y_o == a_i && v_o == v_i)
            else $error("compare altered result or overflow");
      end
      if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_LOAD ||
          op == OP_INC || op == OP_DEC) begin
         assert_nz_only_R5: assert (v_o == v_i && c_o == c_i && z_o == (y_o == '0))
            else $error("logic/step op touched V or C, or Z wrong");
      end
      if (op == OP_BTST) begin
         assert_bittest_R6: assert (y_o == a_i && c_o == c_i &&
                                    n_o == b_i[MSB] && v_o == b_i[MSB-1])
            else $error("bit test flags wrong");
      end
      if (op == OP_AND_CPY) begin
         assert_and_copy_R9: assert (c_o == (a_i[MSB] & b_i[MSB]))
            else $error("masked copy carry wrong");
      end
      if (op == OP_MASK_SUB) begin
         assert_mask_sub_R12: assert (c_o == ((a_i & x_i) >= b_i) && v_o == v_i)
            else $error("masked subtract carry wrong");
      end
      if (op_i >= 5'd18) begin
         assert_hold_pass_R13: assert (y_o == a_i && n_o == n_i && v_o == v_i &&
                                       z_o == z_i && c_o == c_i)
            else $error("hold code changed state");
      end
   end

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [7:0] a, b, x, y;
   logic [4:0] op;
   logic       ci, di, ni, vi, zi;
   logic       no, vo, zo, co;

   alu8_core u_dut (
      .a_i(a), .b_i(b), .x_i(x), .op_i(op),
      .c_i(ci), .d_i(di), .n_i(ni), .v_i(vi), .z_i(zi),
      .y_o(y), .n_o(no), .v_o(vo), .z_o(zo), .c_o(co)
   );

   typedef struct {
      logic [7:0] ey;
      logic [3:0] ef;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   // driver: fin and ef are {N,V,Z,C}
   task automatic apply(input logic [4:0] o, input logic [7:0] av, input logic [7:0] bv,
                        input logic [7:0] xv, input logic [3:0] fin, input logic dv,
                        input logic [7:0] ey, input logic [3:0] ef, input string tag);
      exp_t it;
      @(posedge clk);
      #1;
      op = o; a = av; b = bv; x = xv; di = dv;
      {ni, vi, zi, ci} = fin;
      it.ey = ey; it.ef = ef; it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: compare away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            total++;
            if (y !== it.ey || {no, vo, zo, co} !== it.ef) begin
               bad++;
               $display("FAIL %s: y=%h flags=%b expected y=%h flags=%b",
                        it.tag, y, {no, vo, zo, co}, it.ey, it.ef);
            end
         end
      end
   end

   initial begin
      op = 5'd18; a = 8'h00; b = 8'h00; x = 8'h00;
      {ni, vi, zi, ci} = 4'b0000; di = 1'b0;
      repeat (3) @(posedge clk);
      // idle state: zero plus zero
      apply(5'd0,  8'h00, 8'h00, 8'h00, 4'b0000, 1'b0, 8'h00, 4'b0010, "R1 idle zero");
      apply(5'd0,  8'h50, 8'h50, 8'h00, 4'b0000, 1'b0, 8'hA0, 4'b1100, "R1 signed overflow");
      apply(5'd0,  8'hFF, 8'h01, 8'h00, 4'b0000, 1'b0, 8'h00, 4'b0011, "R1 wrap to zero");
      apply(5'd0,  8'h10, 8'h20, 8'h00, 4'b0001, 1'b0, 8'h31, 4'b0000, "R1 carry in");
      apply(5'd1,  8'h50, 8'hB0, 8'h00, 4'b0001, 1'b0, 8'hA0, 4'b1100, "R2 overflow borrow");
      apply(5'd1,  8'h05, 8'h03, 8'h00, 4'b0000, 1'b0, 8'h01, 4'b0001, "R2 borrow in");
      apply(5'd1,  8'h00, 8'h01, 8'h00, 4'b0001, 1'b0, 8'hFF, 4'b1000, "R2 underflow");
      apply(5'd0,  8'h19, 8'h28, 8'h00, 4'b0000, 1'b1, 8'h47, 4'b0000, "R3 decimal add");
      apply(5'd0,  8'h99, 8'h01, 8'h00, 4'b0000, 1'b1, 8'h00, 4'b0011, "R3 decimal carry");
      apply(5'd1,  8'h42, 8'h13, 8'h00, 4'b0001, 1'b1, 8'h29, 4'b0001, "R3 decimal sub");
      apply(5'd1,  8'h10, 8'h01, 8'h00, 4'b0001, 1'b1, 8'h09, 4'b0001, "R3 decimal digit borrow");
      apply(5'd2,  8'h40, 8'h40, 8'h00, 4'b0100, 1'b0, 8'h40, 4'b0111, "R4 compare equal");
      apply(5'd2,  8'h10, 8'h20, 8'h00, 4'b0011, 1'b0, 8'h10, 4'b1000, "R4 compare less");
      apply(5'd2,  8'h80, 8'h01, 8'h00, 4'b0000, 1'b1, 8'h80, 4'b0001, "R4 compare ignores c d");
      apply(5'd3,  8'hF0, 8'h0F, 8'h00, 4'b0101, 1'b0, 8'h00, 4'b0111, "R5 and");
      apply(5'd4,  8'h80, 8'h01, 8'h00, 4'b0010, 1'b0, 8'h81, 4'b1000, "R5 or");
      apply(5'd5,  8'hAA, 8'hAA, 8'h00, 4'b1001, 1'b0, 8'h00, 4'b0011, "R5 xor");
      apply(5'd15, 8'hFF, 8'h00, 8'h00, 4'b1000, 1'b0, 8'h00, 4'b0010, "R5 increment");
      apply(5'd16, 8'h00, 8'h00, 8'h00, 4'b0111, 1'b0, 8'hFF, 4'b1101, "R5 decrement");
      apply(5'd17, 8'h00, 8'h7F, 8'h00, 4'b1010, 1'b0, 8'h7F, 4'b0000, "R5 load");
      apply(5'd6,  8'h0F, 8'hC0, 8'h00, 4'b0001, 1'b0, 8'h0F, 4'b1111, "R6 bit test zero");
      apply(5'd6,  8'h01, 8'h01, 8'h00, 4'b1110, 1'b0, 8'h01, 4'b0000, "R6 bit test hit");
      apply(5'd7,  8'h81, 8'h00, 8'h00, 4'b0001, 1'b0, 8'h02, 4'b0001, "R7 shift left");
      apply(5'd8,  8'h01, 8'h00, 8'h00, 4'b1001, 1'b0, 8'h00, 4'b0011, "R7 shift right");
      apply(5'd9,  8'h80, 8'h00, 8'h00, 4'b0001, 1'b0, 8'h01, 4'b0001, "R8 rotate left");
      apply(5'd10, 8'h01, 8'h00, 8'h00, 4'b0000, 1'b0, 8'h00, 4'b0011, "R8 rotate right out");
      apply(5'd10, 8'h02, 8'h00, 8'h00, 4'b0001, 1'b0, 8'h81, 4'b1000, "R8 rotate right in");
      apply(5'd11, 8'hFF, 8'h80, 8'h00, 4'b0000, 1'b0, 8'h80, 4'b1001, "R9 copy set");
      apply(5'd11, 8'h7F, 8'hFF, 8'h00, 4'b0001, 1'b0, 8'h7F, 4'b0000, "R9 copy clear");
      apply(5'd12, 8'h03, 8'hFF, 8'h00, 4'b1000, 1'b0, 8'h01, 4'b0001, "R10 mask shift");
      apply(5'd13, 8'hFF, 8'hC0, 8'h00, 4'b0100, 1'b0, 8'h60, 4'b0001, "R11 both high bits");
      apply(5'd13, 8'h40, 8'hFF, 8'h00, 4'b0001, 1'b0, 8'hA0, 4'b1101, "R11 bit six only");
      apply(5'd13, 8'h80, 8'h80, 8'h00, 4'b0001, 1'b1, 8'hC0, 4'b1100, "R11 bit seven only");
      apply(5'd14, 8'hF0, 8'h10, 8'h3C, 4'b0000, 1'b1, 8'h20, 4'b0001, "R12 masked subtract");
      apply(5'd14, 8'hFF, 8'h06, 8'h05, 4'b0101, 1'b0, 8'hFF, 4'b1100, "R12 masked borrow");
      apply(5'd18, 8'h12, 8'hFF, 8'h00, 4'b1010, 1'b1, 8'h12, 4'b1010, "R13 hold");
      apply(5'd31, 8'h00, 8'hFF, 8'hFF, 4'b0101, 1'b0, 8'h00, 4'b0101, "R13 unused code");
      while (exp_q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule